// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block sits on a simple single-cycle register bus and fronts an array of 32-bit fuse words held in flip-flops. Software loads a word pointer, a bit pointer, a data value and a set of control registers, and then either reads back the fuse word under the pointer or programs one bit of it. A bit is programmed by writing the write-enable register. Each bit can be programmed at most once.

Reading the data-out register returns real fuse contents only while three separate enable registers have their enable bit set. In every other case the read returns a fixed filler value. Every fuse bit has a companion bit in a written map. A second attempt to program the same bit is refused and recorded in a sticky error flag. The same flag records writes to offsets that hold no register. On reset every fuse word is set to all ones, except for two words that hold a serial value and its complement. The written map is cleared on reset.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset, every control register reads 0 and `err` is low. The register offsets are: word pointer 0x00, bit pointer 0x04, bank select 0x08, chip enable 0x0C, clock 0x10, data-in 0x14, data-out 0x18, strobe 0x1C, program 0x20, test control 0x24, test mode 0x28, test repair 0x2C, test read 0x30, trim 0x34, write-enable 0x38.
- R2: After reset, every fuse word holds 0xFFFFFFFF. The exceptions are word SERIAL_WORD, which holds SERIAL_VALUE, and word SERIAL_WORD+1, which holds the bitwise complement of SERIAL_VALUE. The written map is clear after reset, so any bit can be programmed once.
- R3: Every register except data-out reads back the last value written to it. The word pointer keeps only its low log2(DEPTH) bits. Write-enable keeps only bit 0. A read returns data on `rdata` in the cycle after `req`. A write takes effect at the same clock edge on which it is accepted.
- R4: A read of data-out returns the fuse word selected by the word pointer when bit 0 of chip enable, bit 0 of strobe and bit 0 of trim are all 1. Otherwise the read returns 0x000000FF.
- R5: A write to data-out changes no register and no fuse, and does not raise `err`.
- R6: Writing write-enable with bit 0 set while bank select is 0 programs one bit. The bit is chosen by the word pointer and by bits [4:0] of the bit pointer. The bit becomes 1 if data-in is nonzero and 0 if data-in is zero, and it is then marked as written.
- R7: While bank select is nonzero, a write-enable write programs nothing, marks nothing and raises no error.
- R8: A program attempt on a bit that is already marked as written leaves the fuse array unchanged and raises `err`.
- R9: An offset is unmapped when its low two bits are nonzero or when it is 0x3C or above. A read of an unmapped offset returns 0. A write to one changes no register and raises `err`.
- R10: Once `err` is high it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Bus access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | BUS_AW | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle after a read request |
| err | output | 1 | Sticky error: rewrite of a written bit or write to an unmapped offset |

## Verification
Read data is registered. It is due on `rdata` one cycle after the read request and holds until the next read. Register writes, bit programming and the error flag all update at the clock edge that accepts the write, so a read issued in the very next cycle already sees the new state. The bench drives each access on a falling edge, withdraws it on the next falling edge, and samples `rdata` and `err` at that point, half a cycle after the edge that produced them. It compares them against a behavioural model that it updates at the same moment.

// File: rtl/otp_fuse_pkg.sv
// Shared definitions for the fuse controller: register indices and fixed values.
// Assumes register offsets are word aligned and numbered in the order listed.
package otp_fuse_pkg;
    localparam int NUM_REGS  = 15;
    localparam int REG_IDX_W = 4;
    localparam logic [31:0] GATED_READ_VALUE = 32'h0000_00FF;

    typedef enum logic [REG_IDX_W-1:0] {
        RG_ADDR   = 4'd0,
        RG_BITSEL = 4'd1,
        RG_BANK   = 4'd2,
        RG_CE     = 4'd3,
        RG_CLK    = 4'd4,
        RG_DIN    = 4'd5,
        RG_DOUT   = 4'd6,
        RG_STROBE = 4'd7,
        RG_PROG   = 4'd8,
        RG_TCTL   = 4'd9,
        RG_TMODE  = 4'd10,
        RG_TREP   = 4'd11,
        RG_TREAD  = 4'd12,
        RG_TRIM   = 4'd13,
        RG_WEN    = 4'd14
    } reg_idx_e;
endpackage

// File: rtl/otp_bus_decode.sv
// Bus decoder: turns an access into a register index and one write strobe per
// register. Assumes 32-bit accesses only; a misaligned offset is treated as unmapped.
// Data-out never receives a write strobe. Purely combinational.
module otp_bus_decode
    import otp_fuse_pkg::*;
#(
    parameter int BUS_AW = 8
) (
    input  logic                req,
    input  logic                we,
    input  logic [BUS_AW-1:0]   addr,
    output logic                mapped,
    output reg_idx_e            idx,
    output logic [NUM_REGS-1:0] wr_sel,
    output logic                rd_en,
    output logic                bad_wr
);
    localparam int WORD_W = BUS_AW - 2;

    logic [WORD_W-1:0] word;

    // Decode the word offset and check that it is mapped.
    always_comb begin
        word   = addr[BUS_AW-1:2];
        mapped = (addr[1:0] == 2'b00) && (int'(word) < NUM_REGS);
        idx    = mapped ? reg_idx_e'(word[REG_IDX_W-1:0]) : RG_ADDR;
        rd_en  = req && !we;
        bad_wr = req && we && !mapped;
    end

    // One write strobe per writable register; data-out is read-only.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_strobe
        if (g == int'(RG_DOUT)) begin : g_ro
            assign wr_sel[g] = 1'b0;
        end else begin : g_rw
            assign wr_sel[g] = req && we && mapped && (int'(word) == g);
        end
    end
endmodule

// File: rtl/otp_ctrl_regs.sv
// Control register file: one 32-bit register per mapped offset, except data-out,
// which has no storage. The word pointer is masked to the fuse address width, and
// write-enable keeps bit 0 only. Also raises a program request when write-enable
// is written with bit 0 set while bank select is zero.
module otp_ctrl_regs
    import otp_fuse_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REGS-1:0] wr_sel,
    input  logic [31:0]         wdata,
    output logic [31:0]         regs_o [NUM_REGS],
    output logic                prog_fire
);
    logic [31:0] regs_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [31:0] KEEP =
            (g == int'(RG_ADDR)) ? 32'((64'd1 << ADDR_W) - 64'd1) :
            (g == int'(RG_WEN))  ? 32'd1 : 32'hFFFF_FFFF;
        if (g == int'(RG_DOUT)) begin : g_none
            assign regs_q[g] = '0;
        end else begin : g_store
            // Hold the last written value, trimmed to the bits kept.
            always_ff @(posedge clk) begin
                if (!rst_n)         regs_q[g] <= '0;
                else if (wr_sel[g]) regs_q[g] <= wdata & KEEP;
            end
        end
        assign regs_o[g] = regs_q[g];
    end

    // Program request: write-enable set while the main array is selected.
    always_comb begin
        prog_fire = wr_sel[RG_WEN] && wdata[0] && (regs_q[RG_BANK] == '0);
    end

    // R5: the decoder never strobes data-out.
    a_r5_dout_not_written: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel[RG_DOUT]);
    // R3: at most one register is written per access.
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));
    // R7: a write-enable write with bank select nonzero never becomes a program.
    a_r7_bank_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q[RG_BANK] != '0) |-> !prog_fire);
endmodule

// File: rtl/otp_fuse_store.sv
// Fuse storage and written map, both held in flip-flops. Programs one bit per
// request and refuses a bit that is already marked as written.
// Assumes DEPTH is a power of two and that SERIAL_WORD + 1 < DEPTH.
module otp_fuse_store #(
    parameter int          DEPTH        = 64,
    parameter int          ADDR_W       = 6,
    parameter int          SERIAL_WORD  = 60,
    parameter logic [31:0] SERIAL_VALUE = 32'h00C0_FFEE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_fire,
    input  logic [ADDR_W-1:0] word_sel,
    input  logic [4:0]        bit_sel,
    input  logic              din_nz,
    output logic [31:0]       rd_word,
    output logic              wo_violation
);
    logic [31:0] fuse_q [DEPTH];
    logic [31:0] wmap_q [DEPTH];
    logic        already;
    logic        do_prog;

    // Look up the selected word and check whether the selected bit is already written.
    always_comb begin
        rd_word      = fuse_q[word_sel];
        already      = wmap_q[word_sel][bit_sel];
        do_prog      = prog_fire && !already;
        wo_violation = prog_fire && already;
    end

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        localparam logic [31:0] INIT =
            (w == SERIAL_WORD)     ? SERIAL_VALUE :
            (w == SERIAL_WORD + 1) ? ~SERIAL_VALUE : 32'hFFFF_FFFF;

        // Reset to the default contents; on a program, write the bit and mark it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fuse_q[w] <= INIT;
                wmap_q[w] <= '0;
            end else if (do_prog && (int'(word_sel) == w)) begin
                fuse_q[w][bit_sel] <= din_nz;
                wmap_q[w][bit_sel] <= 1'b1;
            end
        end

        // R8: written-map bits are never cleared outside reset.
        a_r8_map_only_sets: assert property (@(posedge clk) disable iff (!rst_n)
            ((wmap_q[w] & $past(wmap_q[w])) == $past(wmap_q[w])));
        // R8: a refused program leaves every fuse word unchanged.
        a_r8_refused_stable: assert property (@(posedge clk) disable iff (!rst_n)
            wo_violation |=> $stable(fuse_q[w]));
    end
endmodule

// File: rtl/otp_fuse_ctrl.sv
// Top of the fuse controller: bus decode, control registers, fuse storage,
// registered read multiplexer and a sticky error flag.
// Assumes one access per req cycle; read data is due in the following cycle.
module otp_fuse_ctrl
    import otp_fuse_pkg::*;
#(
    parameter int          DEPTH        = 64,
    parameter int          BUS_AW       = 8,
    parameter int          SERIAL_WORD  = 60,
    parameter logic [31:0] SERIAL_VALUE = 32'h00C0_FFEE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [BUS_AW-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              err
);
    localparam int ADDR_W = $clog2(DEPTH);

    logic                mapped;
    reg_idx_e            idx;
    logic [NUM_REGS-1:0] wr_sel;
    logic                rd_en;
    logic                bad_wr;
    logic [31:0]         regs [NUM_REGS];
    logic                prog_fire;
    logic [31:0]         fuse_word;
    logic                wo_violation;
    logic                gate_open;
    logic [31:0]         rd_next;
    logic [31:0]         rdata_q;
    logic                err_q;

    otp_bus_decode #(.BUS_AW(BUS_AW)) u_dec (
        .req(req), .we(we), .addr(addr), .mapped(mapped), .idx(idx),
        .wr_sel(wr_sel), .rd_en(rd_en), .bad_wr(bad_wr)
    );

    otp_ctrl_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wdata(wdata),
        .regs_o(regs), .prog_fire(prog_fire)
    );

    otp_fuse_store #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W),
        .SERIAL_WORD(SERIAL_WORD), .SERIAL_VALUE(SERIAL_VALUE)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .prog_fire(prog_fire),
        .word_sel(regs[RG_ADDR][ADDR_W-1:0]), .bit_sel(regs[RG_BITSEL][4:0]),
        .din_nz(regs[RG_DIN] != '0),
        .rd_word(fuse_word), .wo_violation(wo_violation)
    );

    // Choose the read value: zero if unmapped, gated fuse data for data-out, else a register.
    always_comb begin
        gate_open = regs[RG_CE][0] && regs[RG_STROBE][0] && regs[RG_TRIM][0];
        if (!mapped)              rd_next = '0;
        else if (idx == RG_DOUT)  rd_next = gate_open ? fuse_word : GATED_READ_VALUE;
        else                      rd_next = regs[idx];
    end

    // Register the read data so that it appears in the cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_next;
    end

    // Sticky error: set by a bad-offset write or a refused program, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                      err_q <= 1'b0;
        else if (bad_wr || wo_violation) err_q <= 1'b1;
    end

    assign rdata = rdata_q;
    assign err   = err_q;

    // R10: the error flag never falls outside reset.
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    // R9: a read of an unmapped offset returns zero in the next cycle.
    a_r9_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && ((addr[1:0] != 2'b00) || (int'(addr) >= 4 * NUM_REGS)))
        |=> (rdata == '0));
    // R9: a write to an unmapped offset raises the error flag.
    a_r9_bad_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && ((addr[1:0] != 2'b00) || (int'(addr) >= 4 * NUM_REGS))) |=> err);
    // R4: with any enable bit clear, a data-out read returns the filler value.
    a_r4_gated_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && (int'(addr) == 4 * int'(RG_DOUT)) &&
         !(regs[RG_CE][0] && regs[RG_STROBE][0] && regs[RG_TRIM][0]))
        |=> (rdata == GATED_READ_VALUE));
    // R8: a refused program always raises the error flag.
    a_r8_refusal_flags: assert property (@(posedge clk) disable iff (!rst_n)
        wo_violation |=> err);
endmodule

// File: tb/otp_fuse_ctrl_test.sv
// Self-checking bench with a behavioural reference model of registers, fuses and written map.
module otp_fuse_ctrl_test;
    localparam int          DEPTH  = 64;
    localparam int          SWORD  = 60;
    localparam logic [31:0] SVAL   = 32'h00C0_FFEE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [31:0] m_reg  [15];
    logic [31:0] m_fuse [DEPTH];
    logic [31:0] m_map  [DEPTH];
    logic        m_err;

    otp_fuse_ctrl #(.DEPTH(DEPTH), .BUS_AW(8), .SERIAL_WORD(SWORD), .SERIAL_VALUE(SVAL)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .err(err)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 15; i++) m_reg[i] = '0;
        for (int i = 0; i < DEPTH; i++) begin
            m_fuse[i] = 32'hFFFF_FFFF;
            m_map[i]  = '0;
        end
        m_fuse[SWORD]   = SVAL;
        m_fuse[SWORD+1] = ~SVAL;
        m_err = 1'b0;
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int i;
        if (a[1:0] != 0 || a >= 8'h3C) return '0;
        i = int'(a >> 2);
        if (i == 6) begin
            if (m_reg[3][0] && m_reg[7][0] && m_reg[13][0]) return m_fuse[m_reg[0]];
            return 32'hFF;
        end
        return m_reg[i];
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        int i;
        int w;
        int b;
        if (a[1:0] != 0 || a >= 8'h3C) begin
            m_err = 1'b1;
            return;
        end
        i = int'(a >> 2);
        case (i)
            0: m_reg[0] = d % DEPTH;
            6: ;
            14: begin
                m_reg[14] = {31'd0, d[0]};
                if (d[0] && m_reg[2] == 0) begin
                    w = int'(m_reg[0]);
                    b = int'(m_reg[1][4:0]);
                    if (m_map[w][b]) m_err = 1'b1;
                    else begin
                        m_fuse[w][b] = (m_reg[5] != 0);
                        m_map[w][b]  = 1'b1;
                    end
                end
            end
            default: m_reg[i] = d;
        endcase
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d, input string tag);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        model_write(a, d);
        chk(err == m_err, {tag, " err"}, {31'd0, err}, {31'd0, m_err});
    endtask

    task automatic do_read(input logic [7:0] a, input string tag);
        logic [31:0] exp;
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        req = 1'b0;
        exp = model_read(a);
        chk(rdata === exp, tag, rdata, exp);
        chk(err == m_err, {tag, " err"}, {31'd0, err}, {31'd0, m_err});
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < 15; i++) do_read(8'(4 * i), tag);
    endtask

    initial begin
        model_reset();
        do_reset();
        // R1: reset state of every register (data-out gated, so R4 too)
        read_all("R1");

        // R3: readback, word pointer masking, write-enable bit 0 only
        do_write(8'h00, 32'hFFFF_FFC5, "R3");
        do_write(8'h04, 32'd3, "R3");
        do_write(8'h10, 32'hA5A5_5A5A, "R3");
        do_write(8'h20, 32'h1234_5678, "R3");
        do_write(8'h24, 32'hDEAD_BEEF, "R3");
        do_write(8'h28, 32'h0F0F_0F0F, "R3");
        do_write(8'h2C, 32'h8000_0001, "R3");
        do_write(8'h30, 32'h0000_FFFF, "R3");
        do_write(8'h38, 32'hFFFF_FFFE, "R3");
        read_all("R3");

        // R4: only chip enable set -> filler; then all three -> fuse data
        do_write(8'h0C, 32'h1, "R4");
        do_read(8'h18, "R4");
        do_write(8'h1C, 32'h3, "R4");
        do_read(8'h18, "R4");
        do_write(8'h34, 32'h1, "R4");
        do_read(8'h18, "R4");

        // R2: default contents, serial word and its complement
        do_write(8'h00, 32'(SWORD), "R2");
        do_read(8'h18, "R2");
        do_write(8'h00, 32'(SWORD + 1), "R2");
        do_read(8'h18, "R2");
        do_write(8'h00, 32'(SWORD - 1), "R2");
        do_read(8'h18, "R2");

        // R5: data-out write has no effect
        do_write(8'h18, 32'h1234_5678, "R5");
        read_all("R5");

        // R6: clear a bit with zero data, set bits with nonzero data
        do_write(8'h00, 32'd5, "R6");
        do_write(8'h14, 32'd0, "R6");
        do_write(8'h38, 32'd1, "R6");
        do_read(8'h18, "R6");
        do_write(8'h04, 32'd37, "R6");
        do_write(8'h38, 32'd1, "R6");
        do_read(8'h18, "R6");
        do_write(8'h00, 32'(SWORD), "R6");
        do_write(8'h04, 32'd0, "R6");
        do_write(8'h14, 32'h80, "R6");
        do_write(8'h38, 32'd1, "R6");
        do_read(8'h18, "R6");

        // R7: bank select nonzero blocks programming and marking
        do_write(8'h00, 32'd5, "R7");
        do_write(8'h04, 32'd10, "R7");
        do_write(8'h14, 32'd0, "R7");
        do_write(8'h08, 32'd1, "R7");
        do_write(8'h38, 32'd1, "R7");
        do_read(8'h18, "R7");
        do_write(8'h08, 32'd0, "R7");
        do_write(8'h38, 32'd1, "R7");
        do_read(8'h18, "R7");

        // R8: second program of bit 3 of word 5 is refused
        do_write(8'h04, 32'd3, "R8");
        do_write(8'h14, 32'd1, "R8");
        do_write(8'h38, 32'd1, "R8");
        do_read(8'h18, "R8");

        // R10: flag stays high through further traffic
        do_write(8'h10, 32'd7, "R10");
        do_read(8'h10, "R10");
        do_read(8'h18, "R10");

        // R2: reset restores contents and clears the written map
        do_reset();
        do_write(8'h0C, 32'h1, "R2");
        do_write(8'h1C, 32'h1, "R2");
        do_write(8'h34, 32'h1, "R2");
        do_write(8'h00, 32'd5, "R2");
        do_read(8'h18, "R2");
        do_write(8'h04, 32'd3, "R2");
        do_write(8'h38, 32'd1, "R2");
        do_read(8'h18, "R2");

        // R9: unmapped reads return zero, unmapped writes flag and change nothing
        do_read(8'h3C, "R9");
        do_read(8'h41, "R9");
        do_read(8'hFC, "R9");
        do_write(8'h01, 32'hFFFF_FFFF, "R9");
        read_all("R9");
        do_write(8'h3C, 32'h5555_5555, "R9");
        read_all("R9");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule